// File: doc/BRIEF.md
# Nonvolatile command sequence detector

This block sits on the control and address pins of a static RAM that has a nonvolatile shadow array. It watches for a fixed series of six read addresses. Each address counts as one step, and each step is clocked in by a falling edge of active-low chip enable. Five fixed prefix addresses must arrive in order. The sixth address then selects a STORE (RAM contents copied into the nonvolatile array) or a RECALL (the nonvolatile array copied back into the RAM). The block emits a one-cycle start pulse for the chosen operation.

Chip enable and write enable are first synchronised to the system clock. The address is captured in the cycle where the synchronised chip enable is seen to fall, so the address must stay stable while chip enable is low. Once an operation starts, a counter holds a busy flag for a programmable number of cycles, and the duration depends on the operation. While busy is high, the data output drivers are held off and the detector ignores new steps. When the operation ends, the detector is back in its idle state.

Top module: `nvseq_detect`

## Requirements
- R1: Five prefix addresses (defaults 0x0E38, 0x31C7, 0x03E0, 0x3C1F, 0x303F) on consecutive steps, then 0x0FC0 on the sixth step, make `store_o` high for exactly one cycle. The pulse appears three rising clock edges after `ce_ni` falls.
- R2: The same prefix followed by 0x0C63 on the sixth step makes `recall_o` high for exactly one cycle. `store_o` stays low.
- R3: A step whose address is not the expected next address returns the detector to idle. The series must then start again from its first address.
- R4: A mismatching step whose address equals the first prefix address counts as step one of a new series.
- R5: A step taken while `we_ni` is low (a write) is not valid and returns the detector to idle.
- R6: `oe_ni` has no effect on detection. Series with output enable high, low or mixed give the same results.
- R7: A chip enable low pulse of two clock cycles counts as a full step.
- R8: `busy_o` rises in the cycle after a start pulse. It stays high for STORE_CYC cycles after a STORE and for RECALL_CYC cycles after a RECALL.
- R9: Steps taken while `busy_o` is high are ignored. When busy ends the detector is idle, so a lone sixth address starts nothing.
- R10: `dout_en_o` is high only when `ce_ni` is low, `oe_ni` is low, `we_ni` is high and `busy_o` is low. It is therefore low for the whole busy period.
- R11: After reset, `store_o`, `recall_o` and `busy_o` are low and the detector is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | RAM address bus |
| ce_ni | input | 1 | Chip enable, active low; its falling edge clocks a step |
| we_ni | input | 1 | Write enable, active low; must be high for a valid step |
| oe_ni | input | 1 | Output enable, active low; gates only `dout_en_o` |
| store_o | output | 1 | One-cycle STORE start pulse |
| recall_o | output | 1 | One-cycle RECALL start pulse |
| busy_o | output | 1 | High while a nonvolatile operation runs |
| dout_en_o | output | 1 | Data output driver enable |

## Verification
A table of steps is applied in order. It contains:
- a clean STORE series and a clean RECALL series, which tell the two sixth addresses apart;
- a series broken by a foreign address, which shows that progress is lost on a mismatch;
- a series broken by a repeated first address, which shows the restart-as-step-one rule as distinct from a plain reset;
- a series containing one write step;
- series with output enable high, low and mixed, which show it is ignored.

Directed tests then cover:
- a series built from two-cycle enable pulses;
- the busy length for each operation;
- a full series fed during busy, followed by a lone sixth address, which separates "ignored" from "still counting";
- the output-enable gating, with and without busy.

// File: rtl/nvseq_pkg.sv
package nvseq_pkg;
  localparam int unsigned ADDR_W    = 15;
  localparam int unsigned N_PREFIX  = 5;

  typedef logic [N_PREFIX-1:0][ADDR_W-1:0] prefix_t;

  // index 0 is the first step of the series
  localparam prefix_t PREFIX_DEF = {15'h303F, 15'h3C1F, 15'h03E0, 15'h31C7, 15'h0E38};
  localparam logic [ADDR_W-1:0] STORE_ADDR_DEF  = 15'h0FC0;
  localparam logic [ADDR_W-1:0] RECALL_ADDR_DEF = 15'h0C63;

  typedef enum logic [1:0] {
    OP_NONE   = 2'b00,
    OP_STORE  = 2'b01,
    OP_RECALL = 2'b10
  } nv_op_e;
endpackage

// File: rtl/nvseq_ce_sync.sv
module nvseq_ce_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_ni,
  input  logic we_ni,
  output logic strobe_o,
  output logic we_ok_o
);
  logic [STAGES-1:0] ce_q, we_q;
  logic              ce_last_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          ce_q[i] <= 1'b1;
          we_q[i] <= 1'b1;
        end else begin
          ce_q[i] <= ce_ni;
          we_q[i] <= we_ni;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          ce_q[i] <= 1'b1;
          we_q[i] <= 1'b1;
        end else begin
          ce_q[i] <= ce_q[i-1];
          we_q[i] <= we_q[i-1];
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ce_last_q <= 1'b1;
    else         ce_last_q <= ce_q[STAGES-1];
  end

  assign strobe_o = ce_last_q & ~ce_q[STAGES-1];
  assign we_ok_o  = we_q[STAGES-1];

  // one step per enable-low pulse
  assert_single_strobe_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |=> !strobe_o);
endmodule

// File: rtl/nvseq_matcher.sv
module nvseq_matcher
  import nvseq_pkg::*;
#(
  parameter int unsigned      AW          = ADDR_W,
  parameter int unsigned      NP          = N_PREFIX,
  parameter logic [NP-1:0][AW-1:0] PREFIX = PREFIX_DEF,
  parameter logic [AW-1:0]    STORE_ADDR  = STORE_ADDR_DEF,
  parameter logic [AW-1:0]    RECALL_ADDR = RECALL_ADDR_DEF
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          strobe_i,
  input  logic          we_ok_i,
  input  logic          block_i,
  input  logic [AW-1:0] addr_i,
  output logic          store_o,
  output logic          recall_o
);
  localparam int unsigned STEP_W = $clog2(NP + 2);
  localparam int unsigned HIT_N  = 2 ** STEP_W;
  localparam logic [STEP_W-1:0] LAST = STEP_W'(NP);

  logic [STEP_W-1:0] step_q, step_d;
  logic [HIT_N-1:0]  hit;
  logic              hit_store, hit_recall;
  nv_op_e            op_d, op_q;

  for (genvar i = 0; i < HIT_N; i++) begin : g_cmp
    if (i < NP) begin : g_lane
      assign hit[i] = (addr_i == PREFIX[i]);
    end else begin : g_pad
      assign hit[i] = 1'b0;
    end
  end

  assign hit_store  = (addr_i == STORE_ADDR);
  assign hit_recall = (addr_i == RECALL_ADDR);

  always_comb begin
    step_d = step_q;
    op_d   = OP_NONE;
    if (strobe_i && !block_i) begin
      if (!we_ok_i) begin
        step_d = '0;
      end else if (step_q < LAST && hit[step_q]) begin
        step_d = step_q + 1'b1;
      end else if (step_q == LAST && hit_store) begin
        step_d = '0;
        op_d   = OP_STORE;
      end else if (step_q == LAST && hit_recall) begin
        step_d = '0;
        op_d   = OP_RECALL;
      end else begin
        step_d = hit[0] ? STEP_W'(1) : '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= '0;
      op_q   <= OP_NONE;
    end else begin
      step_q <= step_d;
      op_q   <= op_d;
    end
  end

  assign store_o  = (op_q == OP_STORE);
  assign recall_o = (op_q == OP_RECALL);

  assert_step_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_q <= LAST);
  assert_write_step_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && !block_i && !we_ok_i) |=> (step_q == '0));
  assert_store_addr_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_o |-> ($past(strobe_i) && $past(addr_i) == STORE_ADDR));
  assert_recall_addr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recall_o |-> ($past(strobe_i) && $past(addr_i) == RECALL_ADDR));
  assert_pulse_one_cycle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (store_o || recall_o) |=> !(store_o || recall_o));
  assert_ops_exclusive_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(store_o && recall_o));
  assert_blocked_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    block_i |=> $stable(step_q));
endmodule

// File: rtl/nvseq_busy_timer.sv
module nvseq_busy_timer #(
  parameter int unsigned STORE_CYC  = 4000,
  parameter int unsigned RECALL_CYC = 500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic store_i,
  input  logic recall_i,
  output logic busy_o
);
  localparam int unsigned MAX_CYC = (STORE_CYC > RECALL_CYC) ? STORE_CYC : RECALL_CYC;
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (store_i)          cnt_q <= CNT_W'(STORE_CYC);
    else if (recall_i)         cnt_q <= CNT_W'(RECALL_CYC);
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);

  assert_busy_after_start_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (store_i || recall_i) |=> busy_o);
endmodule

// File: rtl/nvseq_detect.sv
module nvseq_detect
  import nvseq_pkg::*;
#(
  parameter int unsigned      AW          = ADDR_W,
  parameter logic [N_PREFIX-1:0][AW-1:0] PREFIX = PREFIX_DEF,
  parameter logic [AW-1:0]    STORE_ADDR  = STORE_ADDR_DEF,
  parameter logic [AW-1:0]    RECALL_ADDR = RECALL_ADDR_DEF,
  parameter int unsigned      SYNC_STAGES = 2,
  parameter int unsigned      STORE_CYC   = 4000,
  parameter int unsigned      RECALL_CYC  = 500
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          ce_ni,
  input  logic          we_ni,
  input  logic          oe_ni,
  output logic          store_o,
  output logic          recall_o,
  output logic          busy_o,
  output logic          dout_en_o
);
  logic strobe, we_ok, block;

  nvseq_ce_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ce_ni    (ce_ni),
    .we_ni    (we_ni),
    .strobe_o (strobe),
    .we_ok_o  (we_ok)
  );

  // also block in the start cycle, before busy has risen
  assign block = busy_o | store_o | recall_o;

  nvseq_matcher #(
    .AW          (AW),
    .NP          (N_PREFIX),
    .PREFIX      (PREFIX),
    .STORE_ADDR  (STORE_ADDR),
    .RECALL_ADDR (RECALL_ADDR)
  ) u_match (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strobe_i (strobe),
    .we_ok_i  (we_ok),
    .block_i  (block),
    .addr_i   (addr_i),
    .store_o  (store_o),
    .recall_o (recall_o)
  );

  nvseq_busy_timer #(
    .STORE_CYC  (STORE_CYC),
    .RECALL_CYC (RECALL_CYC)
  ) u_busy (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .store_i  (store_o),
    .recall_i (recall_o),
    .busy_o   (busy_o)
  );

  assign dout_en_o = ~ce_ni & ~oe_ni & we_ni & ~busy_o;

  assert_hiz_while_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !dout_en_o);
  assert_no_start_while_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> !(store_o || recall_o));
endmodule

// File: tb/nvseq_detect_tb.sv
module nvseq_detect_tb;
  localparam int unsigned AW   = 15;
  localparam int unsigned SCYC = 120;
  localparam int unsigned RCYC = 60;

  localparam logic [AW-1:0] A0 = 15'h0E38, A1 = 15'h31C7, A2 = 15'h03E0,
                            A3 = 15'h3C1F, A4 = 15'h303F,
                            ST = 15'h0FC0, RC = 15'h0C63, XX = 15'h1234;

  // {req[3:0], exp_store, exp_recall, we_n, oe_n, addr}
  localparam int unsigned NV = 39;
  localparam logic [22:0] VEC [NV] = '{
    // R1 + R6: STORE, oe mixed
    {4'd1,2'b00,2'b10,A0}, {4'd1,2'b00,2'b11,A1}, {4'd1,2'b00,2'b10,A2},
    {4'd1,2'b00,2'b11,A3}, {4'd1,2'b00,2'b10,A4}, {4'd1,2'b10,2'b11,ST},
    // R2: RECALL
    {4'd2,2'b00,2'b10,A0}, {4'd2,2'b00,2'b10,A1}, {4'd2,2'b00,2'b10,A2},
    {4'd2,2'b00,2'b10,A3}, {4'd2,2'b00,2'b10,A4}, {4'd2,2'b01,2'b10,RC},
    // R3: foreign address breaks the series
    {4'd3,2'b00,2'b10,A0}, {4'd3,2'b00,2'b10,A1}, {4'd3,2'b00,2'b10,XX},
    {4'd3,2'b00,2'b10,A2}, {4'd3,2'b00,2'b10,A3}, {4'd3,2'b00,2'b10,A4},
    {4'd3,2'b00,2'b10,ST},
    // R4: repeated first address restarts as step one
    {4'd4,2'b00,2'b10,A0}, {4'd4,2'b00,2'b10,A1}, {4'd4,2'b00,2'b10,A0},
    {4'd4,2'b00,2'b10,A1}, {4'd4,2'b00,2'b10,A2}, {4'd4,2'b00,2'b10,A3},
    {4'd4,2'b00,2'b10,A4}, {4'd4,2'b10,2'b10,ST},
    // R5: write step in the middle
    {4'd5,2'b00,2'b10,A0}, {4'd5,2'b00,2'b10,A1}, {4'd5,2'b00,2'b00,A2},
    {4'd5,2'b00,2'b10,A3}, {4'd5,2'b00,2'b10,A4}, {4'd5,2'b00,2'b10,ST},
    // R6: oe held high throughout
    {4'd6,2'b00,2'b11,A0}, {4'd6,2'b00,2'b11,A1}, {4'd6,2'b00,2'b11,A2},
    {4'd6,2'b00,2'b11,A3}, {4'd6,2'b00,2'b11,A4}, {4'd6,2'b01,2'b11,RC}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic store, recall, busy, dout_en;

  int n_chk = 0, n_fail = 0;
  int st_cnt = 0, rc_cnt = 0, busy_cnt = 0;

  always #5 clk = ~clk;

  nvseq_detect #(.STORE_CYC(SCYC), .RECALL_CYC(RCYC)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .ce_ni(ce_n), .we_ni(we_n),
    .oe_ni(oe_n), .store_o(store), .recall_o(recall), .busy_o(busy),
    .dout_en_o(dout_en)
  );

  always @(negedge clk) begin
    if (store)  st_cnt++;
    if (recall) rc_cnt++;
    if (busy)   busy_cnt++;
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input logic [AW-1:0] a, input logic w, input logic o, input int lowc);
    @(negedge clk);
    addr = a; we_n = w; oe_n = o; ce_n = 1'b0;
    repeat (lowc) @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 1000 && busy; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got 1 expected 0");
    finish_run();
  end

  initial begin
    int s0, r0, b0;
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11 store", int'(store), 0);
    check("R11 recall", int'(recall), 0);
    check("R11 busy", int'(busy), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R11 busy after release", int'(busy), 0);

    for (int v = 0; v < NV; v++) begin
      s0 = st_cnt; r0 = rc_cnt;
      step(VEC[v][14:0], VEC[v][16], VEC[v][15], 4);
      check($sformatf("R%0d store vec %0d", VEC[v][22:19], v), st_cnt - s0, int'(VEC[v][18]));
      check($sformatf("R%0d recall vec %0d", VEC[v][22:19], v), rc_cnt - r0, int'(VEC[v][17]));
      wait_idle();
    end

    // R7: two-cycle enable pulses
    s0 = st_cnt;
    step(A0,1,0,2); step(A1,1,0,2); step(A2,1,0,2);
    step(A3,1,0,2); step(A4,1,0,2); step(ST,1,0,2);
    check("R7 short pulses store", st_cnt - s0, 1);
    wait_idle();

    // R1: pulse timing, three edges after ce falls; R8 store busy length
    step(A0,1,0,4); step(A1,1,0,4); step(A2,1,0,4); step(A3,1,0,4); step(A4,1,0,4);
    @(negedge clk);
    addr = ST; ce_n = 1'b0;
    b0 = busy_cnt;
    @(negedge clk); @(negedge clk);
    check("R1 no pulse yet", int'(store), 0);
    @(negedge clk);
    check("R1 pulse third edge", int'(store), 1);
    check("R8 busy not yet", int'(busy), 0);
    // R10: busy forces drivers off even with ce/oe low
    oe_n = 1'b0;
    @(negedge clk);
    check("R8 busy rises", int'(busy), 1);
    check("R1 pulse one cycle", int'(store), 0);
    check("R10 hiz while busy", int'(dout_en), 0);
    ce_n = 1'b1; oe_n = 1'b1;
    wait_idle();
    check("R8 store busy length", busy_cnt - b0, SCYC);

    // R8 recall busy length
    step(A0,1,0,4); step(A1,1,0,4); step(A2,1,0,4); step(A3,1,0,4); step(A4,1,0,4);
    b0 = busy_cnt; r0 = rc_cnt;
    step(RC,1,0,4);
    wait_idle();
    check("R2 recall pulse", rc_cnt - r0, 1);
    check("R8 recall busy length", busy_cnt - b0, RCYC);

    // R9: full series during busy ignored, idle afterwards
    step(A0,1,0,4); step(A1,1,0,4); step(A2,1,0,4); step(A3,1,0,4); step(A4,1,0,4);
    step(ST,1,0,4);
    s0 = st_cnt;
    step(A0,1,0,4); step(A1,1,0,4); step(A2,1,0,4); step(A3,1,0,4); step(A4,1,0,4);
    step(ST,1,0,4);
    check("R9 still busy", int'(busy), 1);
    check("R9 no start while busy", st_cnt - s0, 0);
    wait_idle();
    step(ST,1,0,4);
    check("R9 lone sixth after busy", st_cnt - s0, 0);
    step(A0,1,0,4); step(A1,1,0,4); step(A2,1,0,4); step(A3,1,0,4); step(A4,1,0,4);
    step(ST,1,0,4);
    check("R9 fresh series works", st_cnt - s0, 1);
    wait_idle();

    // R10: driver gating when idle
    @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = XX;
    #1 check("R10 read drives", int'(dout_en), 1);
    oe_n = 1'b1;
    #1 check("R10 oe high off", int'(dout_en), 0);
    oe_n = 1'b0; we_n = 1'b0;
    #1 check("R10 write off", int'(dout_en), 0);
    ce_n = 1'b1; we_n = 1'b1;
    #1 check("R10 ce high off", int'(dout_en), 0);
    repeat (6) @(negedge clk);

    finish_run();
  end
endmodule